// File: doc/BRIEF.md
# Service Acknowledge Address Matcher with Initialisation Sequencer

This block sits on the host bus of a multi-channel communications controller. It holds three match registers, one each for the receive, transmit and modem service classes. When the host runs a service acknowledge cycle, it raises an acknowledge strobe and places a 7-bit address on the bus. The block then returns a data-transfer acknowledge only if that address equals the low seven bits of one of the three registers. On a miss, no acknowledge comes back at all, and the host bus cycle is left hanging. Software must therefore load the registers with exactly the values its acknowledge cycles will present.

The block also sequences start-up. Either the active-low hardware reset or a write of 0x81 to the command location clears all state and starts a fixed initialisation interval. While that interval runs, the global status location reads 0x00 and acknowledge cycles are ignored. When it completes, the status location reads 0xFF, which tells software that the match registers may be loaded and that service cycles may begin.

Top module: `svc_ack_matcher`

## Requirements
- R1: While `rst_n` is low and right after it is released, the three match registers read 0x00 and the status location reads 0x00.
- R2: The status location (`reg_sel` = 3) reads 0xFF from the 64th rising clock edge with `rst_n` high onward, and reads 0x00 before that edge.
- R3: A write of 0x81 to `reg_sel` = 3 clears the match registers and the status at that clock edge, exactly as a hardware reset does. The status then reads 0xFF again 64 edges after the edge of the write.
- R4: A write of any other value to `reg_sel` = 3 changes nothing: the status and the match registers keep their values.
- R5: Writes to `reg_sel` 0, 1 and 2 load the receive, transmit and modem match registers, all 8 bits. Reads of them are combinational.
- R6: The block must be initialised, and the strobe must rise while `bus_addr` equals the low 7 bits of any match register. When both hold, `dt_ack` goes high at the next edge, stays high while the strobe stays high, and is low after the first edge at which the strobe is low.
- R7: If the address matches no register in the cycle where the strobe rises, `dt_ack` stays low for the whole strobe, even if the address later changes to a matching value.
- R8: Before initialisation completes, `dt_ack` is never driven. A strobe that is already active when initialisation completes is never acknowledged.
- R9: Bit 7 of a match register takes no part in the comparison.
- R10: A software reset written during an acknowledged strobe drops `dt_ack` at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| wr_en | input | 1 | Register write enable |
| reg_sel | input | 2 | 0 receive match, 1 transmit match, 2 modem match, 3 command (write) / status (read) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `reg_sel` |
| ack_strobe | input | 1 | Service acknowledge cycle active, high |
| bus_addr | input | 7 | Address presented during the acknowledge cycle |
| dt_ack | output | 1 | Data-transfer acknowledge |

## Verification
Register reads are combinational and take effect in the same cycle as the write edge, so the status flips at the 64th edge after reset release and not one edge later. `dt_ack` is registered and appears one edge after the strobe rises. It falls one edge after the strobe falls, or at the very edge of a software reset. The bench updates its reference model at each rising edge from the inputs driven at the preceding falling edge. It compares `rd_data` and `dt_ack` 1 ns after that edge, so every expected value lines up with the cycle in which the registered output moves. The boundary edges are checked one cycle at a time: the status turning to 0xFF, a strobe that straddles that moment, and a reset that lands inside an acknowledge.

// File: rtl/svc_ack_matcher.sv
module svc_ack_matcher #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int INIT_CYCLES = 64,
  parameter logic [7:0] SW_RESET_CODE = 8'h81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ack_strobe,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              dt_ack
);

  localparam int CNT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(INIT_CYCLES);
  localparam logic [1:0] SEL_CMD = 2'd3;

  logic [DATA_W-1:0] mreg [3];
  logic [CNT_W-1:0]  init_cnt;
  logic              strobe_q;
  logic              ready;
  logic              soft_rst;
  logic              hit;

  assign ready    = (init_cnt == CNT_DONE);
  assign soft_rst = wr_en && (reg_sel == SEL_CMD) && (wr_data == DATA_W'(SW_RESET_CODE));

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < 3; i++)
      if (mreg[i][ADDR_W-1:0] == bus_addr) hit = 1'b1;
  end

  always_comb begin
    case (reg_sel)
      2'd0:    rd_data = mreg[0];
      2'd1:    rd_data = mreg[1];
      2'd2:    rd_data = mreg[2];
      default: rd_data = ready ? '1 : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) mreg[i] <= '0;
      init_cnt <= '0;
      strobe_q <= 1'b0;
      dt_ack   <= 1'b0;
    end else if (soft_rst) begin
      for (int i = 0; i < 3; i++) mreg[i] <= '0;
      init_cnt <= '0;
      strobe_q <= 1'b0;
      dt_ack   <= 1'b0;
    end else begin
      if (wr_en && reg_sel != SEL_CMD) mreg[reg_sel] <= wr_data;
      if (!ready) init_cnt <= init_cnt + 1'b1;
      strobe_q <= ack_strobe;
      dt_ack   <= ack_strobe && (dt_ack || (!strobe_q && ready && hit));
    end
  end

  AST_NO_ACK_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !dt_ack); // R8

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_strobe |=> !dt_ack); // R6

  AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dt_ack) |-> $past(ack_strobe) &&
      ($past(bus_addr) == $past(mreg[0][ADDR_W-1:0]) ||
       $past(bus_addr) == $past(mreg[1][ADDR_W-1:0]) ||
       $past(bus_addr) == $past(mreg[2][ADDR_W-1:0]))); // R7

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !soft_rst |=> ready); // R2

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !ready && !dt_ack && mreg[0] == '0 && mreg[1] == '0 && mreg[2] == '0); // R3

endmodule

// File: tb/svc_ack_matcher_tb_top.sv
`timescale 1ns/1ps
module svc_ack_matcher_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] reg_sel = 2'd3;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ack_strobe = 1'b0;
  logic [6:0] bus_addr = 7'h00;
  logic       dt_ack;

  int vectors = 0;
  int fails   = 0;
  string tag  = "R1";
  bit done    = 1'b0;

  int m_reg [3];
  int m_cnt  = 0;
  bit m_ack  = 1'b0;
  bit m_sprev = 1'b0;

  always #2 clk = ~clk;

  svc_ack_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .ack_strobe(ack_strobe),
    .bus_addr(bus_addr), .dt_ack(dt_ack)
  );

  function automatic int exp_rd();
    if (reg_sel == 2'd3) return (m_cnt == 64) ? 8'hFF : 8'h00;
    return m_reg[reg_sel];
  endfunction

  task automatic check(string req, int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit hit, rdy;
    if (!rst_n || (wr_en && reg_sel == 2'd3 && wr_data == 8'h81)) begin
      m_reg[0] = 0; m_reg[1] = 0; m_reg[2] = 0;
      m_cnt = 0; m_ack = 1'b0; m_sprev = 1'b0;
    end else begin
      rdy = (m_cnt == 64);
      hit = 1'b0;
      for (int i = 0; i < 3; i++) if ((m_reg[i] & 8'h7F) == bus_addr) hit = 1'b1;
      m_ack = ack_strobe && (m_ack || (!m_sprev && rdy && hit));
      m_sprev = ack_strobe;
      if (wr_en && reg_sel != 2'd3) m_reg[reg_sel] = wr_data;
      if (m_cnt < 64) m_cnt++;
    end
    #1;
    if (!done) begin
      check(tag, rd_data, exp_rd(), "rd_data");
      check(tag, dt_ack, m_ack, "dt_ack");
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    wr_en = 1'b1; reg_sel = s; wr_data = d;
    tick();
    wr_en = 1'b0; reg_sel = 2'd3;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tick(3);
    tag = "R1";
    for (int s = 0; s < 4; s++) begin
      reg_sel = 2'(s);
      #1 check("R1", rd_data, 0, "reset read");
    end
    reg_sel = 2'd3;
    rst_n = 1'b1;
    tag = "R8";
    tick(5);
    bus_addr = 7'h00; ack_strobe = 1'b1;
    tick(4);
    ack_strobe = 1'b0;
    tag = "R2";
    tick(50);
    tag = "R8";
    ack_strobe = 1'b1;
    tick(8);
    check("R8", dt_ack, 0, "strobe straddling ready");
    ack_strobe = 1'b0;
    tick();
    check("R2", rd_data, 8'hFF, "status after init");
    tag = "R5";
    wr(2'd0, 8'h15); wr(2'd1, 8'h2A); wr(2'd2, 8'hC3);
    reg_sel = 2'd1; tick();
    check("R5", rd_data, 8'h2A, "transmit match read");
    reg_sel = 2'd3;
    tag = "R6";
    bus_addr = 7'h2A; ack_strobe = 1'b1;
    tick();
    check("R6", dt_ack, 1, "ack after match");
    tick(3);
    ack_strobe = 1'b0;
    tick();
    check("R6", dt_ack, 0, "ack released");
    tag = "R7";
    bus_addr = 7'h10; ack_strobe = 1'b1;
    tick(2);
    bus_addr = 7'h15;
    tick(3);
    check("R7", dt_ack, 0, "miss withholds ack");
    ack_strobe = 1'b0;
    tick(2);
    tag = "R9";
    bus_addr = 7'h43; ack_strobe = 1'b1;
    tick(2);
    check("R9", dt_ack, 1, "bit7 ignored");
    ack_strobe = 1'b0;
    tick(2);
    tag = "R4";
    wr(2'd3, 8'h80);
    wr(2'd3, 8'h01);
    reg_sel = 2'd0; #1 check("R4", rd_data, 8'h15, "match kept");
    reg_sel = 2'd3; #1 check("R4", rd_data, 8'hFF, "status kept");
    tick();
    tag = "R10";
    bus_addr = 7'h15; ack_strobe = 1'b1;
    tick(2);
    check("R10", dt_ack, 1, "ack before soft reset");
    wr(2'd3, 8'h81);
    check("R10", dt_ack, 0, "soft reset drops ack");
    tag = "R3";
    ack_strobe = 1'b0;
    reg_sel = 2'd2; #1 check("R3", rd_data, 0, "match cleared");
    reg_sel = 2'd3; #1 check("R3", rd_data, 0, "status cleared");
    tick(62);
    check("R3", rd_data, 0, "status before 64");
    tick(2);
    check("R3", rd_data, 8'hFF, "status after 64");
    tick(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule